// File: doc/BRIEF.md
# Adaptive Delta Modulation Encoder

This block turns a stream of signed fixed-point samples into a one-bit-per-sample code. It keeps a running estimate of the input. For each accepted sample it emits one bit: 1 when the sample is above the estimate, 0 otherwise. It then moves the estimate up or down by a step in the direction of that bit.

The step size adapts to the bit history. While consecutive bits agree, the last change in the estimate is scaled up by about 1.15. When the bits disagree, the last change is halved. This lets the estimate follow steep slopes quickly and settle with small steps on flat input.

A matching decoder can rebuild the estimate from the bit stream alone, because the update depends only on the bits. The current estimate is also brought out so it can be observed.

Top module: `adm_encoder`

## Requirements
- R1: While `rst_ni` is low, `estimate_o` is 0 and `bit_valid_o` is 0. The stored previous bit resets to 1 and the stored previous change resets to 1.
- R2: The emitted bit is 1 when the sample, taken as two's complement, is strictly greater than the current estimate. It is 0 when the sample is below or equal to the estimate.
- R3: The first accepted sample after reset moves the estimate by exactly 1 LSB, upward if the bit is 1 and downward if the bit is 0.
- R4: When the new bit equals the previous bit, the raw step is floor(P*147/128), where P is the magnitude of the previous estimate change.
- R5: When the new bit differs from the previous bit, the raw step is floor(P/2).
- R6: The estimate rises by the step when the bit is 1 and falls by the step when the bit is 0.
- R7: The step is clamped to the range 1 to MAX_STEP, so no single update changes the estimate by more than MAX_STEP.
- R8: The estimate saturates at the signed limits of DATA_W instead of wrapping. The magnitude of the change actually applied becomes P for the next sample.
- R9: `bit_o`, `estimate_o` and `bit_valid_o` update on the clock edge that accepts a sample. `bit_valid_o` is high for exactly the cycle after each accepted sample.
- R10: In a cycle with `sample_valid_i` low, the estimate, the stored bit history and the stored previous change all stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | DATA_W | Signed input sample, two's complement |
| sample_valid_i | input | 1 | Sample accept strobe |
| bit_o | output | 1 | Encoded bit (1 = up, 0 = down) |
| bit_valid_o | output | 1 | One-cycle strobe marking a new bit |
| estimate_o | output | DATA_W | Current estimate, two's complement |

## Verification
The assertions take for granted a few things about the inputs:
- `sample_valid_i` and `sample_i` are stable around each rising edge.
- MAX_STEP is well below half the signed range, so a single step stays inside the signed comparison width.

The bench drives every input on the falling edge and keeps every sample inside the DATA_W signed range. It sweeps each possible sample value as a constant input from reset. It also drives ramps, triangles, full-swing square waves and idle gaps, which push the estimate into both saturation limits and through both agreement and reversal of the bits.

// File: rtl/adm_pkg.sv
package adm_pkg;
  // 1.15 approximated as 147/128
  localparam int unsigned GROW_NUM = 147;
  localparam int unsigned GROW_SH  = 7;
  localparam int unsigned MIN_STEP = 1;
endpackage

// File: rtl/adm_cmp.sv
module adm_cmp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] est_i,
  output logic              up_o
);
  // strict compare: equal counts as down
  assign up_o = $signed(sample_i) > $signed(est_i);
endmodule

// File: rtl/adm_step.sv
module adm_step #(
  parameter int unsigned STEP_W   = 6,
  parameter int unsigned MAX_STEP = 32,
  parameter int unsigned GROW_NUM = 147,
  parameter int unsigned GROW_SH  = 7,
  parameter int unsigned MIN_STEP = 1
) (
  input  logic [STEP_W-1:0] prev_mag_i,
  input  logic              agree_i,
  output logic [STEP_W-1:0] mag_o
);
  localparam int unsigned NUM_W  = $clog2(GROW_NUM + 1);
  localparam int unsigned PROD_W = STEP_W + NUM_W;

  logic [PROD_W-1:0] prod, grown, shrunk, raw;

  always_comb begin
    prod   = PROD_W'(prev_mag_i) * PROD_W'(GROW_NUM);
    grown  = prod >> GROW_SH;
    shrunk = PROD_W'(prev_mag_i >> 1);
    raw    = agree_i ? grown : shrunk;
    if (raw < PROD_W'(MIN_STEP))
      mag_o = STEP_W'(MIN_STEP);
    else if (raw > PROD_W'(MAX_STEP))
      mag_o = STEP_W'(MAX_STEP);
    else
      mag_o = raw[STEP_W-1:0];
  end
endmodule

// File: rtl/adm_acc.sv
module adm_acc #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STEP_W = 6
) (
  input  logic [DATA_W-1:0] est_i,
  input  logic              up_i,
  input  logic [STEP_W-1:0] mag_i,
  output logic [DATA_W-1:0] est_o,
  output logic [STEP_W-1:0] chg_mag_o
);
  localparam int unsigned SUM_W = DATA_W + 2;
  localparam logic signed [SUM_W-1:0] HI = SUM_W'((64'd1 << (DATA_W - 1)) - 64'd1);
  localparam logic signed [SUM_W-1:0] LO = -HI - SUM_W'(1);

  logic signed [SUM_W-1:0] est_ext, mag_ext, sum, sat, diff;
  logic        [SUM_W-1:0] diff_abs;

  always_comb begin
    est_ext = $signed({{2{est_i[DATA_W-1]}}, est_i});
    mag_ext = $signed({{(SUM_W-STEP_W){1'b0}}, mag_i});
    sum     = up_i ? est_ext + mag_ext : est_ext - mag_ext;
    if (sum > HI)      sat = HI;
    else if (sum < LO) sat = LO;
    else               sat = sum;
    est_o    = sat[DATA_W-1:0];
    diff     = sat - est_ext;
    diff_abs = diff[SUM_W-1] ? SUM_W'(-diff) : SUM_W'(diff);
    // applied change never exceeds mag_i, so it fits STEP_W
    chg_mag_o = diff_abs[STEP_W-1:0];
  end
endmodule

// File: rtl/adm_encoder.sv
module adm_encoder #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MAX_STEP = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_valid_i,
  output logic              bit_o,
  output logic              bit_valid_o,
  output logic [DATA_W-1:0] estimate_o
);
  import adm_pkg::*;

  localparam int unsigned STEP_W = $clog2(MAX_STEP + 1);

  logic [DATA_W-1:0] est_q, est_nxt;
  logic [STEP_W-1:0] prev_mag_q, mag, chg_mag;
  logic              prev_bit_q, up, bit_q, vld_q;

  adm_cmp #(.DATA_W(DATA_W)) u_cmp (
    .sample_i (sample_i),
    .est_i    (est_q),
    .up_o     (up)
  );

  adm_step #(
    .STEP_W   (STEP_W),
    .MAX_STEP (MAX_STEP),
    .GROW_NUM (GROW_NUM),
    .GROW_SH  (GROW_SH),
    .MIN_STEP (MIN_STEP)
  ) u_step (
    .prev_mag_i (prev_mag_q),
    .agree_i    (up == prev_bit_q),
    .mag_o      (mag)
  );

  adm_acc #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_acc (
    .est_i     (est_q),
    .up_i      (up),
    .mag_i     (mag),
    .est_o     (est_nxt),
    .chg_mag_o (chg_mag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      est_q      <= '0;
      prev_bit_q <= 1'b1;
      prev_mag_q <= STEP_W'(MIN_STEP);
      bit_q      <= 1'b0;
      vld_q      <= 1'b0;
    end else begin
      vld_q <= sample_valid_i;
      if (sample_valid_i) begin
        est_q      <= est_nxt;
        prev_bit_q <= up;
        prev_mag_q <= chg_mag;
        bit_q      <= up;
      end
    end
  end

  assign bit_o       = bit_q;
  assign bit_valid_o = vld_q;
  assign estimate_o  = est_q;

  assert_valid_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> bit_valid_o);
  assert_no_spurious_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> !bit_valid_o);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> $stable(estimate_o));
  assert_strict_cmp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> (bit_o == ($signed($past(sample_i)) > $signed($past(estimate_o)))));
  assert_direction_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> (bit_o ? ($signed(estimate_o) >= $signed($past(estimate_o)))
                           : ($signed(estimate_o) <= $signed($past(estimate_o)))));
  assert_step_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> (($signed(estimate_o) - $signed($past(estimate_o)) <= $signed(MAX_STEP)) &&
                     ($signed($past(estimate_o)) - $signed(estimate_o) <= $signed(MAX_STEP))));
endmodule

// File: tb/sim_adm_encoder.sv
`timescale 1ns/1ps
module sim_adm_encoder;
  localparam int DW = 8;
  localparam int MX = 32;
  localparam int HI = (1 << (DW - 1)) - 1;
  localparam int LO = -(1 << (DW - 1));

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic [DW-1:0] sample_i = '0;
  logic          sample_valid_i = 1'b0;
  logic          bit_o, bit_valid_o;
  logic [DW-1:0] estimate_o;

  int n_chk = 0, n_bad = 0;
  int m_est, m_prev, m_bit;
  bit m_first;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  adm_encoder #(.DATA_W(DW), .MAX_STEP(MX)) u0 (
    .clk_i, .rst_ni, .sample_i, .sample_valid_i, .bit_o, .bit_valid_o, .estimate_o
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    sample_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R1 estimate", int'($signed(estimate_o)), 0);
    check("R1 valid", int'(bit_valid_o), 0);
    rst_ni = 1'b1;
    m_est = 0; m_prev = 1; m_bit = 1; m_first = 1;
    @(negedge clk_i);
  endtask

  task automatic send(input int v);
    int b, agree, raw, unsat, nxt, chg;
    b     = (v > m_est) ? 1 : 0;
    agree = (b == m_bit);
    raw   = agree ? (m_prev * 147) / 128 : m_prev / 2;
    if (raw < 1)  raw = 1;
    if (raw > MX) raw = MX;
    unsat = b ? m_est + raw : m_est - raw;
    nxt   = unsat > HI ? HI : (unsat < LO ? LO : unsat);
    chg   = nxt > m_est ? nxt - m_est : m_est - nxt;
    sample_i = DW'(v);
    sample_valid_i = 1'b1;
    @(negedge clk_i);
    check("R9 valid", int'(bit_valid_o), 1);
    check("R2 bit", int'(bit_o), b);
    if (m_first)            check("R3 first estimate", int'($signed(estimate_o)), m_est + (b ? 1 : -1));
    else if (unsat != nxt)  check("R8 saturated estimate", int'($signed(estimate_o)), nxt);
    else if (agree)         check("R4 grown estimate", int'($signed(estimate_o)), nxt);
    else                    check("R5 shrunk estimate", int'($signed(estimate_o)), nxt);
    if (unsat == nxt) check("R7 step bound", int'(chg >= 1 && chg <= MX), 1);
    check("R6 direction", int'(b ? ($signed(estimate_o) >= m_est) : ($signed(estimate_o) <= m_est)), 1);
    m_est = nxt; m_prev = chg; m_bit = b; m_first = 0;
    sample_valid_i = 1'b0;
  endtask

  task automatic idle(input int v);
    sample_i = DW'(v);
    sample_valid_i = 1'b0;
    @(negedge clk_i);
    check("R9 no strobe", int'(bit_valid_o), 0);
    check("R10 hold", int'($signed(estimate_o)), m_est);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    do_reset();
    send(0);                     // equal -> down by 1
    do_reset();
    send(5);
    for (int v = LO; v <= HI; v++) send(v);
    for (int k = 0; k < 6; k++) begin
      for (int v = -100; v < 100; v += 7) send(v);
      for (int v = 100; v > -100; v -= 7) send(v);
    end
    for (int k = 0; k < 40; k++) send(HI);
    idle(-50); idle(0);
    for (int k = 0; k < 60; k++) send(LO);
    for (int k = 0; k < 40; k++) send((k % 4 < 2) ? 90 : -90);
    for (int k = 0; k < 30; k++) begin send(k); if (k % 3 == 0) idle(-k); end
    for (int v = LO; v <= HI; v++) begin
      do_reset();
      for (int k = 0; k < 24; k++) send(v);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule